// File: doc/BRIEF.md
# Two-Channel Pulse Width Modulator

This block drives two pulse-width modulated output pins from one shared PWM time base. Software programs it through a small byte-addressed register port: one packed control word holds eight control bits per channel, and each channel has its own period length (range) and high-count (data) register. A channel clock-enable input, `pwm_tick`, advances every running channel by one PWM slot; the fast system clock only moves registers.

Each channel runs a small state machine with three states. `CH_OFF` drives the idle level. `CH_MARKSPACE` outputs a single high run of DATA slots at the start of every RANGE-slot period. `CH_DENSITY` spreads the same number of high slots evenly across the period with an accumulator: each slot adds DATA, and a slot is high when the sum reaches RANGE, in which case RANGE is taken back off. The transitions are `start_mark` (OFF to MARKSPACE on enable with mark-space selected), `start_density` (OFF to DENSITY on enable with mark-space clear), `to_density` and `to_mark` (switching the mark-space bit while running) and `halt` (any running state to OFF when the enable bit clears). Every transition restarts the period at slot 0 and loads the programmed RANGE and DATA.

The serializer, FIFO, repeat and clear bits are kept in the control word so software reads back what it wrote, but they change nothing on the pins.

Top module: `dpwm_top`

## Requirements
- R1: After reset every register reads 0 and both pins are low.
- R2: Registers sit at byte offsets 0x00 (control), 0x10 (channel 0 range), 0x14 (channel 0 data), 0x20 (channel 1 range), 0x24 (channel 1 data); a read returns data combinationally in the same cycle as the address, and any other offset reads 0.
- R3: Control bits 7:0 belong to channel 0 and bits 15:8 to channel 1 (bit 0/8 enable, 1/9 serializer select, 2/10 repeat, 3/11 idle level, 4/12 invert, 5/13 FIFO select, 6 FIFO clear, 7/15 mark-space select); bits 6 and 14 and bits 31:16 always read 0, all other bits read back as written.
- R4: A running channel with mark-space selected is high for slots 0 to DATA-1 of each RANGE-slot period and low for the rest.
- R5: A running channel with mark-space clear is high in a slot exactly when the accumulator plus DATA is at least RANGE; each RANGE-slot window then holds exactly DATA high slots.
- R6: When DATA is at least RANGE (RANGE non-zero) a running channel is high in every slot, in either mode.
- R7: A running channel with RANGE 0 drives its idle level.
- R8: The pin equals the idle-level bit when the channel is off and the raw waveform otherwise, inverted when the invert bit is set.
- R9: RANGE and DATA writes reach a running channel only at the next period boundary.
- R10: Enabling a channel, or changing its mark-space bit while it runs, restarts it at slot 0 with the accumulator cleared, one clock after the control write.
- R11: The slot counter advances only in clocks where `pwm_tick` is high, and stays below the loaded RANGE.
- R12: The two channels run independently, and the serializer, repeat, FIFO-select and FIFO-clear bits have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, same cycle |
| pwm_tick | input | 1 | PWM slot enable shared by both channels |
| pwm_out | output | 2 | Channel output pins, bit 0 is channel 0 |

## Verification
The hardest situation to reach from the ports is a RANGE or DATA write landing in the middle of a running period: whether the old value is kept depends on exactly where the slot counter stands, and that counter is hidden. The directed part gets there by enabling a channel with DATA 0 so the counter starts from a known slot 0, then writing DATA one clock later and checking the pin stays low until the boundary. The random part then throws register writes, mode changes and gapped ticks at both channels together, and a per-cycle reference model in the bench catches every mid-period update and restart.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    // Per-channel state of the output sequencer
    typedef enum logic [1:0] {
        CH_OFF        = 2'd0,
        CH_MARKSPACE  = 2'd1,
        CH_DENSITY    = 2'd2
    } ch_state_e;

    localparam int NUM_CH      = 2;
    localparam int CFG_BITS    = 8;

    // Bit positions inside one channel's control byte
    localparam int BIT_RUN     = 0;
    localparam int BIT_SER     = 1;
    localparam int BIT_RPT     = 2;
    localparam int BIT_IDLE    = 3;
    localparam int BIT_INV     = 4;
    localparam int BIT_FIFO    = 5;
    localparam int BIT_CLR     = 6;
    localparam int BIT_MS      = 7;

    // Bits stored per channel byte: the clear bit never holds a value
    localparam logic [CFG_BITS-1:0] CFG_KEEP = 8'hBF;

    // Byte offsets
    localparam int OFF_CTRL    = 'h00;
    localparam int OFF_STRIDE  = 'h10;
    localparam int OFF_DATA    = 'h04;

endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
    import dpwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int NCH    = NUM_CH
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata,
    output logic [CFG_BITS*NCH-1:0]         ctrl_q,
    output logic [NCH-1:0][CNT_W-1:0]       rng_q,
    output logic [NCH-1:0][CNT_W-1:0]       dat_q
);

    localparam int CTRL_W = CFG_BITS * NCH;
    localparam logic [CTRL_W-1:0] CTRL_MASK = {NCH{CFG_KEEP}};

    function automatic logic [ADDR_W-1:0] rng_off(input int c);
        return ADDR_W'(OFF_STRIDE * (c + 1));
    endfunction

    function automatic logic [ADDR_W-1:0] dat_off(input int c);
        return ADDR_W'(OFF_STRIDE * (c + 1) + OFF_DATA);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && addr == ADDR_W'(OFF_CTRL)) begin
            ctrl_q <= wdata[CTRL_W-1:0] & CTRL_MASK;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chreg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rng_q[c] <= '0;
                dat_q[c] <= '0;
            end else if (wr_en) begin
                if (addr == rng_off(c)) rng_q[c] <= wdata[CNT_W-1:0];
                if (addr == dat_off(c)) dat_q[c] <= wdata[CNT_W-1:0];
            end
        end
    end

    if (DATA_W > CNT_W) begin : g_hi
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_CTRL)) begin
            rdata[CTRL_W-1:0] = ctrl_q;
        end
        for (int c = 0; c < NCH; c++) begin
            if (addr == rng_off(c)) rdata[CNT_W-1:0] = rng_q[c];
            if (addr == dat_off(c)) rdata[CNT_W-1:0] = dat_q[c];
        end
    end

endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
    import dpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             ms_sel,
    input  logic             idle_lvl,
    input  logic             invert,
    input  logic [CNT_W-1:0] rng_prog,
    input  logic [CNT_W-1:0] dat_prog,
    output logic             pin,
    output logic [CNT_W-1:0] slot_o,
    output logic [CNT_W-1:0] act_rng_o,
    output ch_state_e        state_o
);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] act_rng_q;
    logic [CNT_W-1:0] act_dat_q;
    logic [CNT_W:0]   sum;
    logic             carry;
    logic             saturate;
    logic             rng_zero;
    logic             at_end;
    logic             enter;
    logic             raw;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (run) state_d = ms_sel ? CH_MARKSPACE : CH_DENSITY;  // start_mark / start_density
            end
            CH_MARKSPACE: begin
                if (!run)        state_d = CH_OFF;                      // halt
                else if (!ms_sel) state_d = CH_DENSITY;                 // to_density
            end
            CH_DENSITY: begin
                if (!run)        state_d = CH_OFF;                      // halt
                else if (ms_sel) state_d = CH_MARKSPACE;                // to_mark
            end
            default: state_d = CH_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    assign enter    = (state_d != state_q);
    assign rng_zero = (act_rng_q == '0);
    assign at_end   = rng_zero || (cnt_q == act_rng_q - CNT_W'(1));
    assign saturate = (act_dat_q >= act_rng_q);
    assign sum      = {1'b0, acc_q} + {1'b0, act_dat_q};
    assign carry    = (sum >= {1'b0, act_rng_q});

    // Slot counter, accumulator and period shadows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            act_rng_q <= '0;
            act_dat_q <= '0;
        end else if (enter) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            act_rng_q <= rng_prog;
            act_dat_q <= dat_prog;
        end else if (state_q != CH_OFF && tick) begin
            if (at_end) begin
                cnt_q     <= '0;
                acc_q     <= '0;
                act_rng_q <= rng_prog;
                act_dat_q <= dat_prog;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (state_q == CH_DENSITY && !saturate) begin
                    acc_q <= carry ? CNT_W'(sum - {1'b0, act_rng_q}) : sum[CNT_W-1:0];
                end
            end
        end
    end

    // Output logic
    always_comb begin
        raw = idle_lvl;
        unique case (state_q)
            CH_OFF:       raw = idle_lvl;
            CH_MARKSPACE: raw = rng_zero ? idle_lvl : (cnt_q < act_dat_q);
            CH_DENSITY:   raw = rng_zero ? idle_lvl : (saturate || carry);
            default:      raw = idle_lvl;
        endcase
        pin = raw ^ invert;
    end

    assign slot_o    = cnt_q;
    assign act_rng_o = act_rng_q;
    assign state_o   = state_q;

endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
    import dpwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pwm_tick,
    output logic [1:0]        pwm_out
);

    localparam int NCH = NUM_CH;

    logic [CFG_BITS*NCH-1:0]   ctrl_q;
    logic [NCH-1:0][CNT_W-1:0] rng_q;
    logic [NCH-1:0][CNT_W-1:0] dat_q;
    logic [NCH-1:0][CNT_W-1:0] ch_slot;
    logic [NCH-1:0][CNT_W-1:0] ch_act_rng;
    logic [NCH-1:0][1:0]       ch_st;

    dpwm_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .NCH    (NCH)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .ctrl_q (ctrl_q),
        .rng_q  (rng_q),
        .dat_q  (dat_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int B = CFG_BITS * c;
        ch_state_e st;

        dpwm_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (pwm_tick),
            .run       (ctrl_q[B + BIT_RUN]),
            .ms_sel    (ctrl_q[B + BIT_MS]),
            .idle_lvl  (ctrl_q[B + BIT_IDLE]),
            .invert    (ctrl_q[B + BIT_INV]),
            .rng_prog  (rng_q[c]),
            .dat_prog  (dat_q[c]),
            .pin       (pwm_out[c]),
            .slot_o    (ch_slot[c]),
            .act_rng_o (ch_act_rng[c]),
            .state_o   (st)
        );

        assign ch_st[c] = st;
    end

endmodule

// File: rtl/dpwm_checks.sv
module dpwm_checks
    import dpwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic                          pwm_tick,
    input logic [1:0]                    pwm_out,
    input logic [CFG_BITS*NUM_CH-1:0]    ctrl_q,
    input logic [NUM_CH-1:0][CNT_W-1:0]  slot,
    input logic [NUM_CH-1:0][CNT_W-1:0]  act_rng,
    input logic [NUM_CH-1:0][1:0]        st
);

    logic mapped;
    assign mapped = (bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h10)) ||
                    (bus_addr == ADDR_W'('h14)) || (bus_addr == ADDR_W'('h20)) ||
                    (bus_addr == ADDR_W'('h24));

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == '0);

    p_ctrl_holes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h00)) |->
            (bus_rdata[DATA_W-1:16] == '0 && !bus_rdata[14] && !bus_rdata[6]));

    p_slot_bound_ch0_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (act_rng[0] != '0) |-> slot[0] < act_rng[0]);

    p_slot_bound_ch1_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (act_rng[1] != '0) |-> slot[1] < act_rng[1]);

    p_tick_hold_ch0_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pwm_tick) && $stable(st[0])) |-> $stable(slot[0]));

    p_idle_level_ch0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctrl_q[0]) && !ctrl_q[0]) |-> pwm_out[0] == (ctrl_q[3] ^ ctrl_q[4]));

    p_idle_level_ch1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctrl_q[8]) && !ctrl_q[8]) |-> pwm_out[1] == (ctrl_q[11] ^ ctrl_q[12]));

endmodule

bind dpwm_top dpwm_checks #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pwm_tick  (pwm_tick),
    .pwm_out   (pwm_out),
    .ctrl_q    (ctrl_q),
    .slot      (ch_slot),
    .act_rng   (ch_act_rng),
    .st        (ch_st)
);

// File: tb/dpwm_top_test.sv
`timescale 1ns/1ps
module dpwm_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_tick = 1'b0;
    logic [1:0]  pwm_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit mdl_on = 1'b0;

    always #2 clk = ~clk;

    dpwm_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_tick  (pwm_tick),
        .pwm_out   (pwm_out)
    );

    // Reference model built from the requirements
    logic [15:0] m_ctrl = '0;
    int m_rng [2];
    int m_dat [2];
    int st    [2];
    int cnt   [2];
    int acc   [2];
    int ar    [2];
    int ad    [2];

    initial for (int c = 0; c < 2; c++) begin
        m_rng[c] = 0; m_dat[c] = 0; st[c] = 0; cnt[c] = 0; acc[c] = 0; ar[c] = 0; ad[c] = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0;
            for (int c = 0; c < 2; c++) begin
                m_rng[c] = 0; m_dat[c] = 0; st[c] = 0; cnt[c] = 0; acc[c] = 0; ar[c] = 0; ad[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                logic [7:0] cf;
                int want;
                cf = m_ctrl[8*c +: 8];
                want = !cf[0] ? 0 : (cf[7] ? 1 : 2);
                if (want != st[c]) begin
                    st[c] = want; cnt[c] = 0; acc[c] = 0; ar[c] = m_rng[c]; ad[c] = m_dat[c];
                end else if (st[c] != 0 && pwm_tick) begin
                    if (ar[c] == 0 || cnt[c] == ar[c] - 1) begin
                        cnt[c] = 0; acc[c] = 0; ar[c] = m_rng[c]; ad[c] = m_dat[c];
                    end else begin
                        cnt[c] = cnt[c] + 1;
                        if (st[c] == 2 && ad[c] < ar[c]) begin
                            if (acc[c] + ad[c] >= ar[c]) acc[c] = acc[c] + ad[c] - ar[c];
                            else                         acc[c] = acc[c] + ad[c];
                        end
                    end
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_ctrl   = bus_wdata[15:0] & 16'hBFBF;
                    8'h10: m_rng[0] = int'(bus_wdata[15:0]);
                    8'h14: m_dat[0] = int'(bus_wdata[15:0]);
                    8'h20: m_rng[1] = int'(bus_wdata[15:0]);
                    8'h24: m_dat[1] = int'(bus_wdata[15:0]);
                    default: ;
                endcase
            end
        end
    end

    function automatic logic mout(int c);
        logic [7:0] cf;
        logic raw;
        cf = m_ctrl[8*c +: 8];
        if (st[c] == 0 || ar[c] == 0) raw = cf[3];
        else if (st[c] == 1)          raw = (cnt[c] < ad[c]);
        else                          raw = (ad[c] >= ar[c]) || (acc[c] + ad[c] >= ar[c]);
        return raw ^ cf[4];
    endfunction

    function automatic logic [31:0] mread(logic [7:0] a);
        case (a)
            8'h00:   return {16'h0, m_ctrl};
            8'h10:   return 32'(m_rng[0]);
            8'h14:   return 32'(m_dat[0]);
            8'h20:   return 32'(m_rng[1]);
            8'h24:   return 32'(m_dat[1]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (mdl_on && !done) begin
            for (int c = 0; c < 2; c++) begin
                string tag;
                if (st[c] == 0)      tag = "R8";
                else if (ar[c] == 0) tag = "R7";
                else if (st[c] == 1) tag = "R4/R9/R10";
                else                 tag = "R5/R9/R10";
                chk(pwm_out[c] === mout(c), tag, int'(pwm_out[c]), int'(mout(c)));
            end
            chk(bus_rdata === mread(bus_addr), "R2/R3", int'(bus_rdata), int'(mread(bus_addr)));
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        chk(bus_rdata === exp, tag, int'(bus_rdata), int'(exp));
    endtask

    task automatic win(int c, int n, output int hi, output int maxrun);
        int run;
        hi = 0; maxrun = 0; run = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out[c]) begin
                hi++; run++;
                if (run > maxrun) maxrun = run;
            end else run = 0;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int hi, mr, seed;
        seed = $urandom(32'd20240611);
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        mdl_on = 1'b1;
        pwm_tick = 1'b1;

        // R1: reset state
        rd(8'h00, 32'h0, "R1"); rd(8'h10, 32'h0, "R1"); rd(8'h14, 32'h0, "R1");
        rd(8'h20, 32'h0, "R1"); rd(8'h24, 32'h0, "R1");
        chk(pwm_out === 2'b00, "R1", int'(pwm_out), 0);

        // R2: register map and unmapped offsets
        wr(8'h10, 32'd8); wr(8'h14, 32'd3); wr(8'h20, 32'd10); wr(8'h24, 32'd7);
        rd(8'h10, 32'd8, "R2"); rd(8'h14, 32'd3, "R2");
        rd(8'h20, 32'd10, "R2"); rd(8'h24, 32'd7, "R2");
        rd(8'h04, 32'h0, "R2"); rd(8'h18, 32'h0, "R2"); rd(8'h30, 32'h0, "R2");

        // R3: control holes
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_BFBF, "R3");
        wr(8'h00, 32'h0);

        // R4: mark-space 3 of 8, single run
        wr(8'h00, 32'h0081);
        repeat (3) @(posedge clk);
        win(0, 8, hi, mr);  chk(hi == 3, "R4", hi, 3);
        win(0, 16, hi, mr); chk(mr == 3, "R4", mr, 3);
        // R12: channel 1 untouched while channel 0 runs
        win(1, 8, hi, mr);  chk(hi == 0, "R12", hi, 0);

        // R5: dither 3 of 8, spread out
        wr(8'h00, 32'h0001);
        repeat (3) @(posedge clk);
        win(0, 8, hi, mr);  chk(hi == 3, "R5", hi, 3);
        win(0, 16, hi, mr); chk(mr == 1, "R5", mr, 1);

        // R12: channel 1 mark-space 7 of 10 with channel 0 off
        wr(8'h00, 32'h8100);
        repeat (3) @(posedge clk);
        win(1, 10, hi, mr); chk(hi == 7, "R12", hi, 7);

        // R8: idle level and inversion on an off channel
        wr(8'h00, 32'h8118);
        repeat (2) @(posedge clk);
        win(0, 6, hi, mr); chk(hi == 0, "R8", hi, 0);
        wr(8'h00, 32'h8110);
        repeat (2) @(posedge clk);
        win(0, 6, hi, mr); chk(hi == 6, "R8", hi, 6);
        // R8: inverted running waveform, 5 of 8 high
        wr(8'h00, 32'h0091);
        repeat (3) @(posedge clk);
        win(0, 8, hi, mr); chk(hi == 5, "R8", hi, 5);

        // R6: saturation in both modes
        wr(8'h00, 32'h0); wr(8'h14, 32'd9);
        wr(8'h00, 32'h0081);
        repeat (3) @(posedge clk);
        win(0, 16, hi, mr); chk(hi == 16, "R6", hi, 16);
        wr(8'h00, 32'h0001);
        repeat (3) @(posedge clk);
        win(0, 16, hi, mr); chk(hi == 16, "R6", hi, 16);

        // R7: range 0 holds idle level
        wr(8'h00, 32'h0); wr(8'h10, 32'd0);
        wr(8'h00, 32'h0089);
        repeat (3) @(posedge clk);
        win(0, 10, hi, mr); chk(hi == 10, "R7", hi, 10);
        wr(8'h00, 32'h0081);
        repeat (3) @(posedge clk);
        win(0, 10, hi, mr); chk(hi == 0, "R7", hi, 0);

        // R9: data written mid-period waits for the boundary
        wr(8'h00, 32'h0); wr(8'h10, 32'd16); wr(8'h14, 32'd0);
        wr(8'h00, 32'h0081);
        wr(8'h14, 32'd16);
        win(0, 10, hi, mr); chk(hi == 0, "R9", hi, 0);
        repeat (20) @(posedge clk);
        win(0, 16, hi, mr); chk(hi == 16, "R9", hi, 16);

        // R10/R11: re-enable starts at slot 0, counter frozen without ticks
        pwm_tick = 1'b0;
        wr(8'h00, 32'h0); wr(8'h10, 32'd8); wr(8'h14, 32'd3);
        wr(8'h00, 32'h0081);
        repeat (2) @(posedge clk);
        win(0, 20, hi, mr); chk(hi == 20, "R10", hi, 20);
        chk(hi == 20, "R11", hi, 20);
        pwm_tick = 1'b1;

        // R12: placeholder bits have no effect
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h00A7);
        repeat (3) @(posedge clk);
        win(0, 8, hi, mr); chk(hi == 3, "R12", hi, 3);
        rd(8'h00, 32'h0000_00A7, "R3");

        // Random phase, checked cycle by cycle against the model
        for (int i = 0; i < 6000; i++) begin
            int pick;
            @(posedge clk); #1;
            pwm_tick = ($urandom % 4) != 0;
            bus_wr   = ($urandom % 12) == 0;
            pick = $urandom % 6;
            case (pick)
                0: begin bus_addr = 8'h00; bus_wdata = $urandom; end
                1: begin bus_addr = 8'h10; bus_wdata = $urandom % 12; end
                2: begin bus_addr = 8'h14; bus_wdata = $urandom % 14; end
                3: begin bus_addr = 8'h20; bus_wdata = $urandom % 12; end
                4: begin bus_addr = 8'h24; bus_wdata = $urandom % 14; end
                default: begin bus_addr = 8'($urandom); bus_wdata = $urandom; end
            endcase
        end
        @(posedge clk); #1;
        bus_wr = 1'b0;
        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule